// File: doc/BRIEF.md
# Eight-Channel DAC Code Register Bank

This block is the digital core of an eight-channel, 12-bit digital-to-analog converter. It takes complete 16-bit command words, one per cycle, marked by a valid strobe. The top nibble of each word selects an operation and the lower twelve bits carry its argument. Each channel has two stages: an input register that commands write, and a DAC register that drives the converter code output. Each channel also has a power-up flag.

An active-low load input, `ldac_ni`, moves the codes from the input stage to the DAC stage. A single low cycle copies all eight input registers at once, so every channel switches on the same edge. Holding the input low makes the DAC stage follow the input stage one cycle behind. Broadcast commands preset every register to full scale, and set or clear power flags through a channel bit mask. Serial shifting and the analog path sit outside the block.

Command codes, in `word_i[15:12]`: `0000` no-op; `0001` full-scale preset; `0010` power-up mask; `0011` power-down mask; `0100`–`0111` undefined, treated as no-op; `1ccc` write input register of channel `ccc`.

Top module: `dac_bank`

## Requirements
- R1: While `rst_ni` is low, all input registers, all DAC registers and all power flags are zero.
- R2: A valid word with code `1ccc` loads `word_i[11:0]` into the input register of channel `ccc` only. The other seven input registers are unchanged.
- R3: While `ldac_ni` is high and no preset is applied, the DAC register outputs keep their value, whatever is written to the input registers.
- R4: At every rising edge where `ldac_ni` is low, each DAC register takes the value its input register held before that edge. Holding `ldac_ni` low therefore makes a write appear on `dac_o` one cycle after it reaches the input register.
- R5: A valid word with code `0001` sets every input register and every DAC register to `0xFFF` at that edge, whatever the level of `ldac_ni`. The power flags are left unchanged.
- R6: A valid word with code `0010` sets power flag i for every bit i of `word_i[7:0]` that is one. The other flags are left unchanged.
- R7: A valid word with code `0011` clears power flag i for every bit i of `word_i[7:0]` that is one. The other flags are left unchanged.
- R8: Valid words with code `0000` or `0100`–`0111` change no input register, no DAC register and no power flag.
- R9: When `word_valid_i` is low, `word_i` has no effect on any register or flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| word_valid_i | input | 1 | Marks `word_i` as a command this cycle |
| word_i | input | 16 | Command word: code in [15:12], data in [11:0] |
| ldac_ni | input | 1 | Active-low load of the DAC registers from the input registers |
| dac_o | output | 96 | DAC register codes; channel n in bits [12n+11:12n] |
| pwr_up_o | output | 8 | Power-up flag per channel, bit n for channel n |

## Verification
The input registers are not ports, so they can only be seen by moving them into the DAC stage. After each write burst with the load held high, the bench issues a one-cycle low pulse on `ldac_ni` and compares all eight codes. Each channel gets a distinct value, so a write to the wrong channel, or one that leaks into a neighbour, shows up as a mismatch. For the same reason, the no-op and undefined-code sweep and the ignored-strobe case are each followed by a load pulse, so the state those commands could have corrupted is made visible. The power masks are swept over all 256 values in set and clear pairs against an arithmetic model.

// File: rtl/dac_bank_pkg.sv
package dac_bank_pkg;
  localparam int OPC_NOP    = 0;
  localparam int OPC_PRESET = 1;
  localparam int OPC_PWR_UP = 2;
  localparam int OPC_PWR_DN = 3;
endpackage

// File: rtl/dac_cmd_decode.sv
module dac_cmd_decode
  import dac_bank_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int DATA_W = 12,
  parameter int CODE_W = 4
) (
  input  logic                     valid_i,
  input  logic [CODE_W+DATA_W-1:0] word_i,
  output logic [NUM_CH-1:0]        wr_en_o,
  output logic [DATA_W-1:0]        data_o,
  output logic                     preset_o,
  output logic [NUM_CH-1:0]        pwr_set_o,
  output logic [NUM_CH-1:0]        pwr_clr_o
);
  localparam int WORD_W  = CODE_W + DATA_W;
  localparam int WR_BASE = 1 << (CODE_W - 1);

  logic [CODE_W-1:0] code;
  assign code   = word_i[WORD_W-1 -: CODE_W];
  assign data_o = word_i[DATA_W-1:0];

  // channel writes occupy the upper half of the code space
  for (genvar g = 0; g < NUM_CH; g++) begin : g_wr
    assign wr_en_o[g] = valid_i && (code == CODE_W'(WR_BASE + g));
  end

  assign preset_o = valid_i && (code == CODE_W'(OPC_PRESET));

  always_comb begin
    pwr_set_o = '0;
    pwr_clr_o = '0;
    if (valid_i && code == CODE_W'(OPC_PWR_UP)) pwr_set_o = word_i[NUM_CH-1:0];
    if (valid_i && code == CODE_W'(OPC_PWR_DN)) pwr_clr_o = word_i[NUM_CH-1:0];
  end
endmodule

// File: rtl/dac_chan.sv
module dac_chan #(
  parameter int DATA_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              preset_i,
  input  logic              ldac_ni,
  output logic [DATA_W-1:0] in_o,
  output logic [DATA_W-1:0] dac_o
);
  logic [DATA_W-1:0] in_q, dac_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_q  <= '0;
      dac_q <= '0;
    end else if (preset_i) begin
      in_q  <= '1;
      dac_q <= '1;
    end else begin
      if (wr_en_i) in_q <= data_i;
      if (!ldac_ni) dac_q <= in_q;  // old input value: one cycle behind
    end
  end

  assign in_o  = in_q;
  assign dac_o = dac_q;
endmodule

// File: rtl/dac_pwr_ctrl.sv
module dac_pwr_ctrl #(
  parameter int NUM_CH = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_CH-1:0] set_i,
  input  logic [NUM_CH-1:0] clr_i,
  output logic [NUM_CH-1:0] pwr_o
);
  logic [NUM_CH-1:0] pwr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pwr_q <= '0;
    else         pwr_q <= (pwr_q | set_i) & ~clr_i;
  end

  assign pwr_o = pwr_q;
endmodule

// File: rtl/dac_bank.sv
module dac_bank #(
  parameter int NUM_CH = 8,
  parameter int DATA_W = 12,
  parameter int CODE_W = 4
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       word_valid_i,
  input  logic [CODE_W+DATA_W-1:0]   word_i,
  input  logic                       ldac_ni,
  output logic [NUM_CH*DATA_W-1:0]   dac_o,
  output logic [NUM_CH-1:0]          pwr_up_o
);
  logic [NUM_CH-1:0]        wr_en;
  logic [DATA_W-1:0]        wr_data;
  logic                     preset;
  logic [NUM_CH-1:0]        pwr_set, pwr_clr;
  logic [NUM_CH*DATA_W-1:0] in_flat;

  dac_cmd_decode #(.NUM_CH(NUM_CH), .DATA_W(DATA_W), .CODE_W(CODE_W)) dec_i (
    .valid_i   (word_valid_i),
    .word_i    (word_i),
    .wr_en_o   (wr_en),
    .data_o    (wr_data),
    .preset_o  (preset),
    .pwr_set_o (pwr_set),
    .pwr_clr_o (pwr_clr)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    dac_chan #(.DATA_W(DATA_W)) chan_i (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .wr_en_i  (wr_en[g]),
      .data_i   (wr_data),
      .preset_i (preset),
      .ldac_ni  (ldac_ni),
      .in_o     (in_flat[g*DATA_W +: DATA_W]),
      .dac_o    (dac_o[g*DATA_W +: DATA_W])
    );
  end

  dac_pwr_ctrl #(.NUM_CH(NUM_CH)) pwr_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (pwr_set),
    .clr_i  (pwr_clr),
    .pwr_o  (pwr_up_o)
  );
endmodule

// File: rtl/dac_bank_chk.sv
module dac_bank_chk #(
  parameter int NUM_CH = 8,
  parameter int DATA_W = 12,
  parameter int CODE_W = 4
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic                     word_valid_i,
  input logic [CODE_W+DATA_W-1:0] word_i,
  input logic                     ldac_ni,
  input logic [NUM_CH*DATA_W-1:0] in_flat_i,
  input logic [NUM_CH*DATA_W-1:0] dac_o,
  input logic [NUM_CH-1:0]        pwr_up_o
);
  localparam int WORD_W  = CODE_W + DATA_W;
  localparam int WR_BASE = 1 << (CODE_W - 1);

  logic [CODE_W-1:0] code;
  logic is_preset, is_up, is_dn, is_quiet;
  assign code      = word_i[WORD_W-1 -: CODE_W];
  assign is_preset = word_valid_i && code == CODE_W'(1);
  assign is_up     = word_valid_i && code == CODE_W'(2);
  assign is_dn     = word_valid_i && code == CODE_W'(3);
  assign is_quiet  = !word_valid_i || code == '0 ||
                     (code >= CODE_W'(4) && code < CODE_W'(WR_BASE));

  always @(posedge clk_i)
    if (!rst_ni)
      a_r1_reset: assert (dac_o == '0 && in_flat_i == '0 && pwr_up_o == '0);

  for (genvar g = 0; g < NUM_CH; g++) begin : g_wr
    a_r2_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (word_valid_i && code == CODE_W'(WR_BASE + g)) |=>
        in_flat_i[g*DATA_W +: DATA_W] == $past(word_i[DATA_W-1:0]));
  end

  a_r3_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ldac_ni && !is_preset) |=> $stable(dac_o));

  a_r4_copy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ldac_ni && !is_preset) |=> dac_o == $past(in_flat_i));

  a_r5_preset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_preset |=> (dac_o == '1 && in_flat_i == '1 && $stable(pwr_up_o)));

  a_r6_pwr_up: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_up |=> (pwr_up_o & $past(word_i[NUM_CH-1:0])) == $past(word_i[NUM_CH-1:0]));

  a_r7_pwr_dn: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_dn |=> (pwr_up_o & $past(word_i[NUM_CH-1:0])) == '0);

  a_r8_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_quiet |=> ($stable(in_flat_i) && $stable(pwr_up_o)));
endmodule

bind dac_bank dac_bank_chk #(.NUM_CH(NUM_CH), .DATA_W(DATA_W), .CODE_W(CODE_W)) chk_i (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .word_valid_i (word_valid_i),
  .word_i       (word_i),
  .ldac_ni      (ldac_ni),
  .in_flat_i    (in_flat),
  .dac_o        (dac_o),
  .pwr_up_o     (pwr_up_o)
);

// File: tb/dac_bank_tb_top.sv
module dac_bank_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 8;
  localparam int DW  = 12;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b1;
  logic              word_valid_i = 1'b0;
  logic [15:0]       word_i = '0;
  logic              ldac_ni = 1'b1;
  logic [NCH*DW-1:0] dac_o;
  logic [NCH-1:0]    pwr_up_o;

  int errors = 0;
  int checks = 0;
  logic [DW-1:0]  in_m  [NCH];
  logic [DW-1:0]  dac_m [NCH];
  logic [NCH-1:0] pwr_m;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  dac_bank dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .word_valid_i(word_valid_i),
    .word_i(word_i), .ldac_ni(ldac_ni), .dac_o(dac_o), .pwr_up_o(pwr_up_o)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    for (int ch = 0; ch < NCH; ch++)
      check(dac_o[ch*DW +: DW] === dac_m[ch], req, $sformatf("dac ch%0d", ch),
            32'(dac_o[ch*DW +: DW]), 32'(dac_m[ch]));
    check(pwr_up_o === pwr_m, req, "pwr", 32'(pwr_up_o), 32'(pwr_m));
  endtask

  // called at a falling edge; returns at the next falling edge
  task automatic step(input bit v, input logic [15:0] w, input bit ld);
    logic [DW-1:0] old_in [NCH];
    word_valid_i = v;
    word_i       = w;
    ldac_ni      = ld;
    @(posedge clk_i);
    old_in = in_m;
    if (v && w[15:12] == 4'h1) begin
      for (int ch = 0; ch < NCH; ch++) begin
        in_m[ch]  = '1;
        dac_m[ch] = '1;
      end
    end else begin
      if (v && w[15]) in_m[w[14:12]] = w[11:0];
      if (!ld) dac_m = old_in;
    end
    if (v && w[15:12] == 4'h2) pwr_m = pwr_m | w[7:0];
    if (v && w[15:12] == 4'h3) pwr_m = pwr_m & ~w[7:0];
    @(negedge clk_i);
    word_valid_i = 1'b0;
  endtask

  function automatic logic [DW-1:0] pat(input int ch, input int k);
    return DW'((ch + 1) * 12'h1A3 + k * 12'h0F1);
  endfunction

  initial begin
    for (int ch = 0; ch < NCH; ch++) begin
      in_m[ch]  = '0;
      dac_m[ch] = '0;
    end
    pwr_m = '0;
    #1 rst_ni = 1'b0;
    repeat (3) @(negedge clk_i);
    check_all("R1");
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R2/R3: writes with load held high leave outputs alone
    for (int ch = 0; ch < NCH; ch++) begin
      step(1'b1, {1'b1, 3'(ch), pat(ch, 0)}, 1'b1);
      check_all("R3");
    end
    step(1'b0, 16'h0, 1'b0);
    check_all("R2");

    // R4: held low, follow one cycle late
    step(1'b1, {4'hD, 12'h5C3}, 1'b0);
    check_all("R4");
    step(1'b0, 16'h0, 1'b0);
    check_all("R4");

    // R9: strobe low ignores word
    step(1'b0, {4'h9, 12'hABC}, 1'b1);
    step(1'b0, {4'h1, 12'h000}, 1'b1);
    step(1'b0, {4'h2, 12'h0FF}, 1'b0);
    check_all("R9");

    // R8: no-op and undefined codes
    for (int c = 0; c < 8; c++) begin
      if (c == 1 || c == 2 || c == 3) continue;
      step(1'b1, {4'(c), 12'hFFF}, 1'b1);
    end
    step(1'b0, 16'h0, 1'b0);
    check_all("R8");

    // R6/R7: power mask sweep
    for (int m = 0; m < 256; m++) begin
      step(1'b1, {4'h2, 4'h0, 8'(m)}, 1'b1);
      check_all("R6");
      step(1'b1, {4'h3, 4'h0, 8'(m ^ 8'h5A)}, 1'b1);
      check_all("R7");
    end
    step(1'b1, {4'h2, 12'h0C5}, 1'b1);

    // R5: preset with load high, power untouched
    step(1'b1, {4'h1, 12'h000}, 1'b1);
    check_all("R5");

    // R2: write sweep per channel, transparent load
    for (int k = 1; k < 17; k++)
      for (int ch = 0; ch < NCH; ch++) begin
        step(1'b1, {1'b1, 3'(ch), pat(ch, k)}, 1'b0);
        step(1'b0, 16'h0, 1'b0);
        check_all("R2");
      end

    // R5 again, with load low
    step(1'b1, {4'h1, 12'h123}, 1'b0);
    check_all("R5");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    errors++;
    checks++;
    $display("FAIL watchdog expired, all requirements");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule